// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Per-Output Source Select

This block is the divider and distribution stage behind a clock synthesizer. Two divider banks each count the edges of their own source clock. Each source is presented as a tick strobe in the system clock domain. A bank produces three taps: one through a programmable integer divisor and two through fixed ratios. The first bank's fixed ratios are /2 and /3. The second bank's fixed ratios are /2 and /4. All taps are registered levels in the system clock domain. Six outputs each pick one of eight sources through a 3-bit code and can be forced low by an enable bit.

The divisor, select and enable inputs are meant to come from a serial-programmed register file. The block checks the programmed combination. It raises a configuration-error flag when a divisor is out of range, or when an output selects a fixed tap whose rule on the bank divisor is broken. A new divisor is picked up only when the running count wraps, so a reprogrammed output never shows a shortened phase.

Top module: `clkfab_top`

## Requirements
- R1: Output k takes its select code from `src_sel[3k+2:3k]`. Codes 0..7 mean: reference, bank 1 divisor tap, bank 1 /2, bank 1 /3, bank 2 divisor tap, bank 2 /2, bank 2 /4, reserved.
- R2: A divisor tap with active divisor N repeats every N ticks of its bank. It is high for the first ceil(N/2) ticks of the count and low for the rest, so odd N has the high phase one tick longer. After reset the count is 0 and the level is high.
- R3: The fixed taps are divide-by counters of ratio 2, 3 (bank 1) and 2, 4 (bank 2). They use the same duty rule as R2.
- R4: A divisor input that changes mid-count becomes active only on the tick that ends the current count (count N-1 wrapping to 0).
- R5: A bank divisor outside 4..127 is loaded as 8 at the next wrap. Such a divisor also raises `cfg_err` one cycle later, whatever the select codes are.
- R6: `cfg_err` is also raised one cycle later when any output selects one of these taps with its rule broken: bank 1 /2 with N1 not a multiple of 4; bank 1 /3 with N1 not equal to 6; bank 2 /2 with N2 not a multiple of 4; bank 2 /4 with N2 not a multiple of 8. Otherwise `cfg_err` is low.
- R7: An output whose `out_en` bit is 0 is driven low one cycle later.
- R8: An output selecting the reserved code 7 is driven low one cycle later.
- R9: An enabled output shows a bank tap's level one cycle after the tap register changes. It shows `ref_in` two cycles after `ref_in` is sampled.
- R10: During and right after reset, all outputs and `cfg_err` are low, and both bank divisors are 8.
- R11: A bank's taps hold their level while its tick input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference level passed to code 0 |
| bank1_tick | input | 1 | Source-clock edge strobe for bank 1 |
| bank2_tick | input | 1 | Source-clock edge strobe for bank 2 |
| bank1_div | input | 8 | Bank 1 integer divisor |
| bank2_div | input | 8 | Bank 2 integer divisor |
| src_sel | input | 18 | Six packed 3-bit select codes, output k at bits 3k+2:3k |
| out_en | input | 6 | Per-output enable |
| clk_out | output | 6 | Divided clock outputs |
| cfg_err | output | 1 | Illegal-configuration flag |

## Verification
The outputs are tried with several tick patterns: ticks on every cycle, ticks on alternate cycles, and pseudo-random ticks. Each pattern is used with even, odd and out-of-range divisors. This separates a wrong duty split from a wrong period, and a divider that counts system clocks from one that counts ticks. The divisor is rewritten at cycles unrelated to the count, so an early load of the new value shows up as a period mismatch. The select patterns cover every code with mixed enables. Legal and illegal divisor pairings separate each tap's divisibility rule from the range check.

// File: rtl/clkfab_pkg.sv
package clkfab_pkg;
    localparam int NUM_OUT  = 6;
    localparam int SEL_W    = 3;
    localparam int DIV_W    = 8;
    localparam int CNT_W    = 7;
    localparam int DIV_MIN  = 4;
    localparam int DIV_MAX  = 127;
    localparam int DIV_SAFE = 8;

    typedef enum logic [SEL_W-1:0] {
        SRC_REF   = 3'd0,
        SRC_B1_N  = 3'd1,
        SRC_B1_D2 = 3'd2,
        SRC_B1_D3 = 3'd3,
        SRC_B2_N  = 3'd4,
        SRC_B2_D2 = 3'd5,
        SRC_B2_D4 = 3'd6,
        SRC_RSV   = 3'd7
    } src_e;
endpackage

// File: rtl/clkfab_divcnt.sv
module clkfab_divcnt #(
    parameter int CW       = 7,
    parameter int DW       = 8,
    parameter int MIN_DIV  = 4,
    parameter int SAFE_DIV = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] div_in,
    output logic          lvl
);
    localparam int MAX_DIV = (1 << CW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cur;
        logic          lvl;
    } st_t;

    st_t           s_d, s_q;
    logic          div_ok;
    logic [CW:0]   half_d;

    always_comb begin
        s_d    = s_q;
        div_ok = (div_in >= DW'(MIN_DIV)) && (div_in <= DW'(MAX_DIV));
        if (tick) begin
            if (s_q.cnt == s_q.cur - CW'(1)) begin
                s_d.cnt = '0;
                s_d.cur = div_ok ? div_in[CW-1:0] : CW'(SAFE_DIV);
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
        half_d  = ({1'b0, s_d.cur} + (CW+1)'(1)) >> 1;
        s_d.lvl = ({1'b0, s_d.cnt} < half_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.cur <= CW'(SAFE_DIV);
            s_q.lvl <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl = s_q.lvl;
endmodule

// File: rtl/clkfab_bank.sv
module clkfab_bank
    import clkfab_pkg::*;
#(
    parameter int CW      = CNT_W,
    parameter int DW      = DIV_W,
    parameter int ALT_DIV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] div_in,
    output logic [2:0]    taps
);
    clkfab_divcnt #(
        .CW(CW), .DW(DW), .MIN_DIV(DIV_MIN), .SAFE_DIV(DIV_SAFE)
    ) u_ndiv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_in(div_in), .lvl(taps[0])
    );

    for (genvar g = 0; g < 2; g++) begin : g_fixed
        localparam int FD = (g == 0) ? 2 : ALT_DIV;
        clkfab_divcnt #(
            .CW(CW), .DW(DW), .MIN_DIV(FD), .SAFE_DIV(FD)
        ) u_fdiv (
            .clk(clk), .rst_n(rst_n), .tick(tick), .div_in(DW'(FD)), .lvl(taps[g+1])
        );
    end
endmodule

// File: rtl/clkfab_top.sv
module clkfab_top
    import clkfab_pkg::*;
#(
    parameter int NOUT = NUM_OUT,
    parameter int DW   = DIV_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_in,
    input  logic                  bank1_tick,
    input  logic                  bank2_tick,
    input  logic [DW-1:0]         bank1_div,
    input  logic [DW-1:0]         bank2_div,
    input  logic [NOUT*SEL_W-1:0] src_sel,
    input  logic [NOUT-1:0]       out_en,
    output logic [NOUT-1:0]       clk_out,
    output logic                  cfg_err
);
    localparam int NSRC = 1 << SEL_W;

    typedef struct packed {
        logic            ref_s;
        logic [NOUT-1:0] outs;
        logic            err;
    } top_st_t;

    top_st_t          s_d, s_q;
    logic [2:0]       b1_taps;
    logic [2:0]       b2_taps;
    logic [NSRC-1:0]  src_vec;
    logic             b1_range_bad, b2_range_bad;
    src_e             sel_k;

    clkfab_bank #(.CW(CNT_W), .DW(DW), .ALT_DIV(3)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .tick(bank1_tick), .div_in(bank1_div), .taps(b1_taps)
    );

    clkfab_bank #(.CW(CNT_W), .DW(DW), .ALT_DIV(4)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .tick(bank2_tick), .div_in(bank2_div), .taps(b2_taps)
    );

    assign src_vec = {1'b0, b2_taps, b1_taps, s_q.ref_s};

    always_comb begin
        s_d          = s_q;
        s_d.ref_s    = ref_in;
        b1_range_bad = (bank1_div < DW'(DIV_MIN)) || (bank1_div > DW'(DIV_MAX));
        b2_range_bad = (bank2_div < DW'(DIV_MIN)) || (bank2_div > DW'(DIV_MAX));
        s_d.err      = b1_range_bad | b2_range_bad;
        for (int k = 0; k < NOUT; k++) begin
            sel_k      = src_e'(src_sel[k*SEL_W +: SEL_W]);
            s_d.outs[k] = out_en[k] & src_vec[sel_k];
            case (sel_k)
                SRC_B1_D2: if (bank1_div[1:0] != 2'b00) s_d.err = 1'b1;
                SRC_B1_D3: if (bank1_div != DW'(6))      s_d.err = 1'b1;
                SRC_B2_D2: if (bank2_div[1:0] != 2'b00) s_d.err = 1'b1;
                SRC_B2_D4: if (bank2_div[2:0] != 3'b000) s_d.err = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign clk_out = s_q.outs;
    assign cfg_err = s_q.err;
endmodule

// File: rtl/clkfab_checker.sv
module clkfab_checker #(
    parameter int NOUT = 6,
    parameter int DW   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bank1_tick,
    input logic [DW-1:0]       bank1_div,
    input logic [DW-1:0]       bank2_div,
    input logic [NOUT*3-1:0]   src_sel,
    input logic [NOUT-1:0]     out_en,
    input logic [NOUT-1:0]     clk_out,
    input logic                cfg_err,
    input logic [2:0]          b1_taps
);
    for (genvar k = 0; k < NOUT; k++) begin : g_out
        // R7: disabled output is low next cycle
        p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |=> !clk_out[k]);
        // R8: reserved code gives a low output next cycle
        p_reserved_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[k*3 +: 3] == 3'd7) |=> !clk_out[k]);
    end

    p_range_flag_b1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank1_div < DW'(4)) || (bank1_div > DW'(127))) |=> cfg_err);

    p_range_flag_b2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank2_div < DW'(4)) || (bank2_div > DW'(127))) |=> cfg_err);

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bank1_tick |=> $stable(b1_taps));
endmodule

bind clkfab_top clkfab_checker #(.NOUT(NOUT), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bank1_tick(bank1_tick),
    .bank1_div(bank1_div), .bank2_div(bank2_div), .src_sel(src_sel),
    .out_en(out_en), .clk_out(clk_out), .cfg_err(cfg_err), .b1_taps(b1_taps)
);

// File: tb/clkfab_top_tb.sv
module clkfab_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        bank1_tick = 1'b0;
    logic        bank2_tick = 1'b0;
    logic [7:0]  bank1_div = 8'd8;
    logic [7:0]  bank2_div = 8'd8;
    logic [17:0] src_sel = '0;
    logic [5:0]  out_en = '0;
    logic [5:0]  clk_out;
    logic        cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int cyc = 0;

    // reference model state: divider index 0..2 bank 1 (N,/2,/3), 3..5 bank 2 (N,/2,/4)
    int m_cnt [6];
    int m_cur [6];
    bit m_lvl [6];
    bit m_ref;
    bit [5:0] m_out;
    bit m_err;

    always #4 clk = ~clk;

    clkfab_top dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .bank1_tick(bank1_tick), .bank2_tick(bank2_tick),
        .bank1_div(bank1_div), .bank2_div(bank2_div),
        .src_sel(src_sel), .out_en(out_en),
        .clk_out(clk_out), .cfg_err(cfg_err)
    );

    function automatic int fixed_div(int j);
        case (j)
            1: return 2;
            2: return 3;
            4: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic model_reset();
        for (int j = 0; j < 6; j++) begin
            m_cnt[j] = 0;
            m_cur[j] = (j == 0 || j == 3) ? 8 : fixed_div(j);
            m_lvl[j] = 1'b1;
        end
        m_ref = 1'b0;
        m_out = '0;
        m_err = 1'b0;
    endtask

    task automatic model_edge();
        bit src [8];
        bit err;
        int n1, n2;
        n1 = int'(bank1_div);
        n2 = int'(bank2_div);
        src[0] = m_ref;
        for (int j = 0; j < 6; j++) src[j+1] = m_lvl[j];
        src[7] = 1'b0;
        err = (n1 < 4 || n1 > 127 || n2 < 4 || n2 > 127);
        for (int k = 0; k < 6; k++) begin
            int s;
            s = int'(src_sel[k*3 +: 3]);
            m_out[k] = out_en[k] && src[s];
            if (s == 2 && (n1 % 4) != 0) err = 1'b1;
            if (s == 3 && n1 != 6)        err = 1'b1;
            if (s == 5 && (n2 % 4) != 0) err = 1'b1;
            if (s == 6 && (n2 % 8) != 0) err = 1'b1;
        end
        m_err = err;
        for (int j = 0; j < 6; j++) begin
            bit t;
            t = (j < 3) ? bank1_tick : bank2_tick;
            if (t) begin
                if (m_cnt[j] == m_cur[j] - 1) begin
                    m_cnt[j] = 0;
                    if (j == 0)      m_cur[j] = (n1 >= 4 && n1 <= 127) ? n1 : 8;
                    else if (j == 3) m_cur[j] = (n2 >= 4 && n2 <= 127) ? n2 : 8;
                end else begin
                    m_cnt[j] = m_cnt[j] + 1;
                end
            end
            m_lvl[j] = (m_cnt[j] < (m_cur[j] + 1) / 2);
        end
        m_ref = ref_in;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    // one cycle: inputs are already set at a falling edge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        check(clk_out == m_out, tag, "clk_out", int'(clk_out), int'(m_out));
        check(cfg_err == m_err, tag, "cfg_err", int'(cfg_err), int'(m_err));
    endtask

    // mode 0: tick every cycle, 1: bank1 alternate / bank2 every third, 2: random, 3: none
    task automatic run(int cycles, int mode, string tag);
        for (int i = 0; i < cycles; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (mode)
                0: begin bank1_tick = 1'b1; bank2_tick = 1'b1; end
                1: begin bank1_tick = (i % 2) == 0; bank2_tick = (i % 3) == 0; end
                2: begin bank1_tick = lfsr[0]; bank2_tick = lfsr[5]; end
                default: begin bank1_tick = 1'b0; bank2_tick = 1'b0; end
            endcase
            if ((i % 3) == 0) ref_in = ~ref_in;
            step(tag);
        end
    endtask

    function automatic logic [17:0] pack_sel(int s0, int s1, int s2, int s3, int s4, int s5);
        return {3'(s5), 3'(s4), 3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R10: reset state
        check(clk_out == 6'b0, "R10", "clk_out", int'(clk_out), 0);
        check(cfg_err == 1'b0, "R10", "cfg_err", int'(cfg_err), 0);
        out_en = 6'h3F;
        rst_n  = 1'b1;

        // R1 R2 R3 R9: every code once, ticks each cycle, divisor 8
        src_sel = pack_sel(0, 1, 2, 3, 4, 5);
        run(120, 0, "R1");
        src_sel = pack_sel(6, 5, 4, 1, 2, 0);
        run(120, 1, "R3");

        // R2: odd divisors, random ticks
        bank1_div = 8'd5;
        bank2_div = 8'd7;
        src_sel = pack_sel(1, 4, 1, 4, 0, 1);
        run(200, 2, "R2");

        // R4: divisors rewritten mid-count
        for (int r = 0; r < 5; r++) begin
            bank1_div = 8'(9 + r * 3);
            bank2_div = 8'(4 + r * 5);
            run(37, 1, "R4");
        end

        // R5: out-of-range divisors fall back to 8
        bank1_div = 8'd200;
        bank2_div = 8'd2;
        src_sel = pack_sel(1, 4, 0, 1, 4, 0);
        run(100, 0, "R5");
        bank1_div = 8'd0;
        bank2_div = 8'd128;
        run(60, 2, "R5");

        // R6: legal pairing then each broken rule
        bank1_div = 8'd6;
        bank2_div = 8'd16;
        src_sel = pack_sel(3, 5, 6, 1, 4, 0);
        run(80, 0, "R6");
        bank2_div = 8'd12;
        run(60, 0, "R6");
        bank1_div = 8'd8;
        bank2_div = 8'd16;
        src_sel = pack_sel(2, 5, 6, 2, 1, 4);
        run(60, 1, "R6");
        bank2_div = 8'd10;
        run(60, 1, "R6");

        // R7 R8: enables and reserved code
        out_en = 6'b101010;
        src_sel = pack_sel(7, 1, 7, 0, 4, 7);
        run(80, 0, "R7");
        out_en = 6'b010101;
        run(60, 2, "R8");

        // R11: no ticks, taps hold
        out_en = 6'h3F;
        src_sel = pack_sel(1, 2, 3, 4, 5, 6);
        run(40, 3, "R11");
        run(40, 2, "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule